// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A miss request carries a 32-bit virtual address. The walker reads the first-level word that the top twelve address bits select. Depending on the descriptor type, it either finishes there with a 1 MB section or a 16 MB supersection, or it follows a pointer to a 256-entry second-level table and finishes with a 4 KB small page or a 64 KB large page. The result is one response: the physical address, a page-size code and a 4-bit attribute field. A refill unit can load that response into its translation buffer.

The 16 MB and 64 KB mappings have no table level of their own. The table builder writes each of them into 16 consecutive descriptors, so every walk reads at most two words. A small register file holds the enable bits, the table base, the status bits that clear when written with 1, the interrupt mask and the last faulting virtual address. When walking is off, a miss is answered at once with an error and a miss interrupt. When a descriptor is invalid, the walk ends with a translation fault.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `resp_valid`, `mem_req` and `irq` are low, `miss_ready` is high, and the control (address 0), status (address 2) and interrupt mask (address 3) registers read zero.
- R2: A base write (address 1) with any of bits 13:0 set leaves the stored base unchanged and marks the table invalid. Walking stays off until an aligned base is written.
- R3: Walking is on only when control bit 0 (translation enable), control bit 1 (walk enable) and a valid base are all present. Otherwise an accepted miss gets an error response in the cycle after acceptance and makes no memory read. It sets status bit 0 and latches the virtual address into the fault-address register (address 4).
- R4: The first read of a walk is at address {base[31:14], va[31:20], 2'b00}.
- R5: A first-level descriptor with bits 1:0 = 10 and bit 18 clear is a section. The walker returns pa = {d[31:20], va[19:0]}, size code 2 and attributes d[11:8].
- R6: A first-level descriptor with bits 1:0 = 10 and bit 18 set is a supersection. The walker returns pa = {d[31:24], va[23:0]}, size code 3 and attributes d[11:8], for every one of its 16 replicated entries.
- R7: A first-level descriptor with bits 1:0 = 01 makes the walker read a second level at {d[31:10], va[19:12], 2'b00}.
- R8: A second-level descriptor with bit 1 set (10 or 11) is a small page. The walker returns pa = {d[31:12], va[11:0]}, size code 0 and attributes d[5:2].
- R9: A second-level descriptor with bits 1:0 = 01 is a large page. The walker returns pa = {d[31:16], va[15:0]}, size code 1 and attributes d[5:2], for any of its 16 replicated entries.
- R10: A first-level type of 00 or 11, or a second-level type of 00, ends the walk with an error response. It sets status bit 1 and latches the virtual address into address 4.
- R11: Status reads return the raw status ANDed with the mask (address 3). `irq` is high when any masked bit is set. Writing 1 to a status bit clears it, and writing 0 has no effect.
- R12: Only one memory read is outstanding at a time. `mem_req` holds with a stable address until `mem_ack`, and `miss_ready` is low while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| miss_valid | input | 1 | miss request present |
| miss_va | input | 32 | virtual address to translate |
| miss_ready | output | 1 | walker can accept a miss |
| resp_valid | output | 1 | one-cycle response strobe |
| resp_err | output | 1 | response carries no translation (fault or walking off) |
| resp_pa | output | 32 | translated physical address |
| resp_size | output | 2 | page size code: 0 4 KB, 1 64 KB, 2 1 MB, 3 16 MB |
| resp_attr | output | 4 | descriptor attribute field |
| mem_req | output | 1 | memory read request, held until ack |
| mem_addr | output | 32 | descriptor address |
| mem_ack | input | 1 | read data valid |
| mem_rdata | input | 32 | descriptor word |
| csr_wr | input | 1 | register write strobe |
| csr_addr | input | 3 | register index |
| csr_wdata | input | 32 | register write data |
| csr_rdata | output | 32 | register read data (combinational) |
| irq | output | 1 | interrupt: any masked status bit set |

## Verification
Two cases are hard to reach from the ports. The first is a fault that occurs only at the second level, after a valid first-level table pointer. The second is a miss that arrives while the base register holds a rejected misaligned value. The bench reaches the first by building a table descriptor whose second-level slot is left empty in its sparse memory model. It reaches the second by writing a misaligned base after an aligned one and then issuing a miss. It also exercises both ends of each replicated 16-entry mapping, and stretches memory latency to watch the request hold steady.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW       = 32;
  localparam int ATTR_W   = 4;
  localparam int TBL_LSB  = 14;   // first-level table alignment (16 KB)
  localparam int CSR_AW   = 3;
  localparam int ST_W     = 2;    // status bits: 0 miss, 1 fault

  typedef enum logic [1:0] {PG_4K = 2'd0, PG_64K = 2'd1, PG_1M = 2'd2, PG_16M = 2'd3} pgsz_e;
  typedef enum logic [1:0] {W_IDLE = 2'd0, W_L1 = 2'd1, W_L2 = 2'd2} wstate_e;

  typedef struct packed {
    logic              ok;
    logic              is_table;
    pgsz_e             size;
    logic [AW-1:0]     pa;
    logic [ATTR_W-1:0] attr;
  } decode_t;

  function automatic logic [AW-1:0] l1_addr(logic [AW-1:0] base, logic [AW-1:0] va);
    return {base[AW-1:TBL_LSB], va[31:20], 2'b00};
  endfunction

  function automatic logic [AW-1:0] l2_addr(logic [AW-1:0] desc, logic [AW-1:0] va);
    return {desc[31:10], va[19:12], 2'b00};
  endfunction

  function automatic decode_t dec_l1(logic [AW-1:0] d, logic [AW-1:0] va);
    decode_t r;
    r = '0;
    case (d[1:0])
      2'b01: begin r.ok = 1'b1; r.is_table = 1'b1; end
      2'b10: begin
        r.ok   = 1'b1;
        r.attr = d[11:8];
        if (d[18]) begin r.size = PG_16M; r.pa = {d[31:24], va[23:0]}; end
        else       begin r.size = PG_1M;  r.pa = {d[31:20], va[19:0]}; end
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic decode_t dec_l2(logic [AW-1:0] d, logic [AW-1:0] va);
    decode_t r;
    r = '0;
    r.attr = d[5:2];
    if (d[1]) begin
      r.ok = 1'b1; r.size = PG_4K;  r.pa = {d[31:12], va[11:0]};
    end else if (d[0]) begin
      r.ok = 1'b1; r.size = PG_64K; r.pa = {d[31:16], va[15:0]};
    end else begin
      r.attr = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/ptw_csr.sv
module ptw_csr
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  output logic [AW-1:0]     csr_rdata,
  input  logic              ev_miss,
  input  logic              ev_fault,
  input  logic [AW-1:0]     ev_va,
  output logic              walk_ok,
  output logic [AW-1:0]     base_addr,
  output logic              irq
);
  logic [1:0]      ctrl_q;
  logic [AW-1:0]   base_q;
  logic            base_ok_q;
  logic [ST_W-1:0] status_q, mask_q, st_set, st_clr, st_vis;
  logic [AW-1:0]   fva_q;

  wire wr_base   = csr_wr && (csr_addr == 3'd1);
  wire base_bad  = |csr_wdata[TBL_LSB-1:0];

  assign st_set  = {ev_fault, ev_miss};
  assign st_clr  = (csr_wr && csr_addr == 3'd2) ? csr_wdata[ST_W-1:0] : '0;
  assign st_vis  = status_q & mask_q;
  assign walk_ok = ctrl_q[0] & ctrl_q[1] & base_ok_q;
  assign base_addr = base_q;
  assign irq     = |st_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; base_q <= '0; base_ok_q <= 1'b0;
      status_q <= '0; mask_q <= '0; fva_q <= '0;
    end else begin
      if (csr_wr && csr_addr == 3'd0) ctrl_q <= csr_wdata[1:0];
      if (csr_wr && csr_addr == 3'd3) mask_q <= csr_wdata[ST_W-1:0];
      if (wr_base) begin
        if (base_bad) base_ok_q <= 1'b0;
        else begin base_q <= csr_wdata; base_ok_q <= 1'b1; end
      end
      status_q <= (status_q & ~st_clr) | st_set;
      if (ev_miss || ev_fault) fva_q <= ev_va;
    end
  end

  always_comb begin
    case (csr_addr)
      3'd0:    csr_rdata = {{(AW-2){1'b0}}, ctrl_q};
      3'd1:    csr_rdata = base_q;
      3'd2:    csr_rdata = {{(AW-ST_W){1'b0}}, st_vis};
      3'd3:    csr_rdata = {{(AW-ST_W){1'b0}}, mask_q};
      3'd4:    csr_rdata = fva_q;
      default: csr_rdata = '0;
    endcase
  end

  p_misalign_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && base_bad) |=> !walk_ok);
  p_fault_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> status_q[1]);
  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == 3'd2 && csr_wdata[1] && !ev_fault) |=> !status_q[1]);
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [AW-1:0]     miss_va,
  output logic              miss_ready,
  input  logic              walk_ok,
  input  logic [AW-1:0]     base_addr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [AW-1:0]     resp_pa,
  output logic [1:0]        resp_size,
  output logic [ATTR_W-1:0] resp_attr,
  output logic              ev_miss,
  output logic              ev_fault,
  output logic [AW-1:0]     ev_va
);
  wstate_e       st_q;
  logic [AW-1:0] va_q;
  decode_t       d1, d2, fin;

  assign d1 = dec_l1(mem_rdata, va_q);
  assign d2 = dec_l2(mem_rdata, va_q);

  wire accept    = miss_valid && miss_ready;
  wire l1_done   = (st_q == W_L1) && mem_ack;
  wire l2_done   = (st_q == W_L2) && mem_ack;
  wire go_l2     = l1_done && d1.ok && d1.is_table;
  wire walk_end  = (l1_done && !go_l2) || l2_done;

  assign fin        = (st_q == W_L1) ? d1 : d2;
  assign mem_req    = (st_q != W_IDLE);
  assign miss_ready = (st_q == W_IDLE) && !resp_valid;
  assign ev_va      = va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; va_q <= '0; mem_addr <= '0;
      resp_valid <= 1'b0; resp_err <= 1'b0; resp_pa <= '0;
      resp_size <= 2'd0; resp_attr <= '0; ev_miss <= 1'b0; ev_fault <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      ev_miss    <= 1'b0;
      ev_fault   <= 1'b0;
      if (accept) begin
        va_q <= miss_va;
        if (walk_ok) begin
          st_q     <= W_L1;
          mem_addr <= l1_addr(base_addr, miss_va);
        end else begin
          resp_valid <= 1'b1; resp_err <= 1'b1; ev_miss <= 1'b1;
          resp_pa <= '0; resp_size <= 2'd0; resp_attr <= '0;
        end
      end
      if (go_l2) begin
        st_q     <= W_L2;
        mem_addr <= l2_addr(mem_rdata, va_q);
      end
      if (walk_end) begin
        st_q       <= W_IDLE;
        resp_valid <= 1'b1;
        resp_err   <= !fin.ok;
        ev_fault   <= !fin.ok;
        resp_pa    <= fin.pa;
        resp_size  <= fin.size;
        resp_attr  <= fin.attr;
      end
    end
  end

  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !miss_ready);
  p_no_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !walk_ok) |=> (!mem_req && resp_valid && resp_err));
  p_first_in_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_addr[AW-1:TBL_LSB] == base_addr[AW-1:TBL_LSB]));
  p_single_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_one_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_miss, ev_fault}));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [AW-1:0]     miss_va,
  output logic              miss_ready,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [AW-1:0]     resp_pa,
  output logic [1:0]        resp_size,
  output logic [ATTR_W-1:0] resp_attr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              csr_wr,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  output logic [AW-1:0]     csr_rdata,
  output logic              irq
);
  logic          walk_ok, ev_miss, ev_fault;
  logic [AW-1:0] base_addr, ev_va;

  ptw_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ev_miss(ev_miss),
    .ev_fault(ev_fault), .ev_va(ev_va), .walk_ok(walk_ok),
    .base_addr(base_addr), .irq(irq)
  );

  ptw_engine u_eng (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_va(miss_va),
    .miss_ready(miss_ready), .walk_ok(walk_ok), .base_addr(base_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_pa(resp_pa), .resp_size(resp_size), .resp_attr(resp_attr),
    .ev_miss(ev_miss), .ev_fault(ev_fault), .ev_va(ev_va)
  );
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_va = '0;
  logic        miss_ready, resp_valid, resp_err, mem_req, irq;
  logic [31:0] resp_pa, mem_addr, csr_rdata;
  logic [1:0]  resp_size;
  logic [3:0]  resp_attr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        csr_wr = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;

  int checks = 0, errors = 0;
  int rd_cnt = 0, busy_viol = 0, mem_lat = 0, wait_cnt = 0;
  logic [31:0] rd_addr [0:3];
  logic [31:0] mem [logic [31:0]];
  bit done = 0;

  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] L2T  = 32'h0008_0400;

  always #4 clk = ~clk;

  ptw_walker u0 (.*);

  // memory responder and handshake monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && miss_ready) busy_viol++;
      if (mem_req && !mem_ack) begin
        if (wait_cnt >= mem_lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
          rd_cnt++;
          wait_cnt = 0;
        end else wait_cnt++;
      end else mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; #1 d = csr_rdata;
  endtask

  task automatic do_miss(input logic [31:0] va, output logic err, output logic [31:0] pa,
                         output logic [1:0] sz, output logic [3:0] at);
    rd_cnt = 0;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_va = va;
    @(negedge clk);
    miss_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    err = resp_err; pa = resp_pa; sz = resp_size; at = resp_attr;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  logic e; logic [31:0] p, r; logic [1:0] s; logic [3:0] a;

  task automatic t_reset();
    chk("R1 resp_valid", {31'b0, resp_valid}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 miss_ready", {31'b0, miss_ready}, 1);
    csr_read(0, r); chk("R1 ctrl", r, 0);
    csr_read(2, r); chk("R1 status", r, 0);
    csr_read(3, r); chk("R1 mask", r, 0);
  endtask

  task automatic t_disabled();
    csr_write(3, 3);
    do_miss(32'h1234_5678, e, p, s, a);
    chk("R3 err when off", {31'b0, e}, 1);
    chk("R3 no memory read", rd_cnt, 0);
    csr_read(2, r); chk("R3 miss status", r, 1);
    chk("R11 irq on miss", {31'b0, irq}, 1);
    csr_read(4, r); chk("R3 fault va", r, 32'h1234_5678);
    csr_write(2, 0); csr_read(2, r); chk("R11 write 0 keeps", r, 1);
    csr_write(2, 1); csr_read(2, r); chk("R11 w1c clears", r, 0);
    chk("R11 irq drops", {31'b0, irq}, 0);
    // translation on, walk enable off, valid base
    csr_write(1, BASE); csr_write(0, 1);
    do_miss(32'h0000_1000, e, p, s, a);
    chk("R3 walk_en off err", {31'b0, e}, 1);
    chk("R3 walk_en off no read", rd_cnt, 0);
    csr_write(2, 3);
  endtask

  task automatic t_misalign();
    csr_write(0, 3);
    csr_write(1, BASE | 32'h2000);
    csr_read(1, r); chk("R2 base unchanged", r, BASE);
    do_miss(32'h1234_5678, e, p, s, a);
    chk("R2 misaligned blocks walk", {31'b0, e}, 1);
    chk("R2 no read", rd_cnt, 0);
    csr_read(2, r); chk("R2 miss status", r, 1);
    csr_write(2, 3);
    csr_write(1, BASE);
  endtask

  task automatic t_section();
    mem[BASE + 32'h48C] = 32'h9AB0_0A02;
    do_miss(32'h1234_5678, e, p, s, a);
    chk("R4 L1 address", rd_addr[0], BASE + 32'h48C);
    chk("R5 err", {31'b0, e}, 0);
    chk("R5 pa", p, 32'h9AB4_5678);
    chk("R5 size", {30'b0, s}, 2);
    chk("R5 attr", {28'b0, a}, 4'hA);
    chk("R5 single read", rd_cnt, 1);
  endtask

  task automatic t_super();
    for (int i = 0; i < 16; i++) mem[BASE + ((32'h340 + i) << 2)] = 32'h5F04_0502;
    do_miss(32'h3456_789A, e, p, s, a);
    chk("R6 pa mid entry", p, 32'h5F56_789A);
    chk("R6 size", {30'b0, s}, 3);
    chk("R6 attr", {28'b0, a}, 4'h5);
    do_miss(32'h3400_0010, e, p, s, a);
    chk("R6 pa first entry", p, 32'h5F00_0010);
    do_miss(32'h34F0_0004, e, p, s, a);
    chk("R6 pa last entry", p, 32'h5FF0_0004);
  endtask

  task automatic t_second_level();
    mem[BASE + 32'h1C] = L2T | 32'h1;
    mem[L2T + 32'h48]  = 32'hCAFE_B026;
    mem[L2T + 32'h4C]  = 32'h1111_100F;
    for (int i = 0; i < 16; i++) mem[L2T + ((32'h40 + i) << 2)] = 32'hBEEF_0019;
    do_miss(32'h0071_2345, e, p, s, a);
    chk("R7 L2 address", rd_addr[1], L2T + 32'h48);
    chk("R7 two reads", rd_cnt, 2);
    chk("R8 small pa", p, 32'hCAFE_B345);
    chk("R8 small size", {30'b0, s}, 0);
    chk("R8 small attr", {28'b0, a}, 4'h9);
    do_miss(32'h0071_3001, e, p, s, a);
    chk("R8 type 11 pa", p, 32'h1111_1001);
    chk("R8 type 11 attr", {28'b0, a}, 4'h3);
    do_miss(32'h0074_5678, e, p, s, a);
    chk("R9 large pa", p, 32'hBEEF_5678);
    chk("R9 large size", {30'b0, s}, 1);
    chk("R9 large attr", {28'b0, a}, 4'h6);
    do_miss(32'h0074_FABC, e, p, s, a);
    chk("R9 large last entry", p, 32'hBEEF_FABC);
  endtask

  task automatic t_faults();
    do_miss(32'hF000_0123, e, p, s, a);
    chk("R10 L1 00 err", {31'b0, e}, 1);
    csr_read(2, r); chk("R10 fault status", r, 2);
    csr_read(4, r); chk("R10 fault va", r, 32'hF000_0123);
    csr_write(3, 1); csr_read(2, r); chk("R11 masked read", r, 0);
    chk("R11 masked irq", {31'b0, irq}, 0);
    csr_write(3, 3); csr_read(2, r); chk("R11 unmasked read", r, 2);
    csr_write(2, 2); csr_read(2, r); chk("R11 fault clear", r, 0);
    mem[BASE + 32'h24] = 32'h0000_0003;
    do_miss(32'h0090_0000, e, p, s, a);
    chk("R10 L1 11 err", {31'b0, e}, 1);
    csr_write(2, 2);
    do_miss(32'h0071_F000, e, p, s, a);
    chk("R10 L2 00 err", {31'b0, e}, 1);
    chk("R10 L2 fault two reads", rd_cnt, 2);
    csr_read(4, r); chk("R10 L2 fault va", r, 32'h0071_F000);
    csr_write(2, 3);
  endtask

  task automatic t_slow_mem();
    mem_lat = 5; busy_viol = 0;
    do_miss(32'h0071_2345, e, p, s, a);
    chk("R12 slow result", p, 32'hCAFE_B345);
    chk("R12 single L2 read", rd_cnt, 2);
    chk("R12 busy while walking", busy_viol, 0);
    mem_lat = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_misalign();
    t_section();
    t_super();
    t_second_level();
    t_faults();
    t_slow_mem();
    finish_run();
  end
endmodule